// File: doc/BRIEF.md
# Root Port Error Status Logger

This block keeps the error-status word of a root port. Three receive strobes report error messages that have arrived from downstream devices: correctable, non-fatal and fatal. Each strobe comes with the 16-bit requester ID of the sender. For each error class, correctable and uncorrectable, the block keeps two flags. One flag marks the first error. The other marks that more errors of the same class followed. The block also records whether the first uncorrectable error was fatal, and has one seen-flag per severity. It stores the requester ID of the first message of each class in a source-identification word.

Software clears the live status bits by writing ones to them through a small write port. The source word cannot be written. Status and logged IDs are sticky. An asserted functional reset leaves them untouched, and only the power-on reset returns them to zero. While the functional reset is held, the block ignores both new events and software clears. The status updates whatever any interrupt or enable settings are.

Top module: `rootport_err_log`

## Requirements
- R1: A correctable strobe sets status bit 0 when bit 0 is clear, and logs its requester ID into `src_id_o[15:0]`.
- R2: A correctable strobe that arrives while bit 0 is already set sets bit 1 and leaves the logged correctable ID unchanged.
- R3: A non-fatal or fatal strobe sets bit 2 when bit 2 is clear, and logs its ID into `src_id_o[31:16]`. If bit 2 is already set, the strobe sets bit 3 instead.
- R4: When bit 2 sets, bit 4 captures the severity of that message (1 = fatal, 0 = non-fatal). Later uncorrectable messages do not change bit 4. If a fatal and a non-fatal strobe arrive in the same cycle, fatal takes priority for both bit 4 and the logged ID.
- R5: Every non-fatal strobe sets bit 5. Every fatal strobe sets bit 6.
- R6: Status bits 31:7 always read as zero.
- R7: A write with `wr_sel`=0 clears each of status bits 6:0 whose `wr_data` bit is 1. A 0 bit in `wr_data` leaves that status bit as it is. A write with `wr_sel`=1 changes neither the status word nor the source word.
- R8: If a set event and a software clear hit the same bit in the same cycle, the bit ends up set.
- R9: While `func_rst_n` is low, the status and source words hold their values even when strobes or writes are present. Only `por_n` low clears them to zero.
- R10: A logged ID stays unchanged while its first-error bit stays set. After software clears that bit, the next message of the class logs a new ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears all state |
| func_rst_n | input | 1 | Functional reset, active low; freezes state, clears nothing |
| cor_vld | input | 1 | Correctable error message received |
| cor_rid | input | 16 | Requester ID of the correctable message |
| nf_vld | input | 1 | Non-fatal error message received |
| nf_rid | input | 16 | Requester ID of the non-fatal message |
| ft_vld | input | 1 | Fatal error message received |
| ft_rid | input | 16 | Requester ID of the fatal message |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = status word, 1 = source word (read-only) |
| wr_data | input | 7 | Write-one-to-clear mask for status bits 6:0 |
| status_o | output | 32 | Error status word |
| src_id_o | output | 32 | Logged IDs: uncorrectable in [31:16], correctable in [15:0] |

## Verification
The collision that matters is a message strobe arriving in the same cycle as a software write-one-to-clear of the flag that strobe sets. The bench fills every flag and then writes the full clear mask while all three strobes pulse. It expects the first-error, multiple and seen bits to survive. It expects the severity bit to clear, because no first uncorrectable event exists to re-capture it. A second collision clears only the correctable first-error bit while a correctable strobe arrives. The bench judges it by the multiple bit rising and by the logged ID staying the same.

// File: rtl/rerr_pkg.sv
package rerr_pkg;
   localparam int COR_FIRST_BIT   = 0;
   localparam int COR_MULTI_BIT   = 1;
   localparam int UNC_FIRST_BIT   = 2;
   localparam int UNC_MULTI_BIT   = 3;
   localparam int FIRST_FATAL_BIT = 4;
   localparam int NF_SEEN_BIT     = 5;
   localparam int FT_SEEN_BIT     = 6;
   localparam int LIVE_BITS       = 7;
   localparam int NUM_CLASSES     = 2;
   localparam int CLS_COR         = 0;
   localparam int CLS_UNC         = 1;

   typedef enum logic {
      SEL_STATUS = 1'b0,
      SEL_SOURCE = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/rerr_class_log.sv
module rerr_class_log #(
   parameter int RID_W = 16
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             upd_en,
   input  logic             ev,
   input  logic [RID_W-1:0] ev_rid,
   input  logic             clr_first,
   input  logic             clr_multi,
   output logic             first,
   output logic             multi,
   output logic [RID_W-1:0] rid_log
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         first   <= 1'b0;
         multi   <= 1'b0;
         rid_log <= '0;
      end else if (upd_en) begin
         if (ev)             first <= 1'b1;
         else if (clr_first) first <= 1'b0;
         if (ev && first)    multi <= 1'b1;
         else if (clr_multi) multi <= 1'b0;
         if (ev && !first)   rid_log <= ev_rid;
      end
   end

   p_first_log_r1: assert property (@(posedge clk) disable iff (!por_n)
      (upd_en && ev && !first) |=> (first && rid_log == $past(ev_rid)));
   p_multi_r2: assert property (@(posedge clk) disable iff (!por_n)
      (upd_en && ev && first) |=> (first && multi));
   p_set_wins_r8: assert property (@(posedge clk) disable iff (!por_n)
      (upd_en && ev && clr_first) |=> first);
   p_id_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
      first |=> (!first || $stable(rid_log)));
endmodule

// File: rtl/rerr_sev_track.sv
module rerr_sev_track #(
   parameter bit FATAL_PRIO = 1'b1
) (
   input  logic clk,
   input  logic por_n,
   input  logic upd_en,
   input  logic nf_ev,
   input  logic ft_ev,
   input  logic unc_first,
   input  logic clr_sev,
   input  logic clr_nf,
   input  logic clr_ft,
   output logic first_fatal,
   output logic nf_seen,
   output logic ft_seen
);
   logic capture;
   logic sev_val;

   assign capture = (nf_ev || ft_ev) && !unc_first;

   generate
      if (FATAL_PRIO) begin : g_fatal_prio
         assign sev_val = ft_ev;
      end else begin : g_nonfatal_prio
         assign sev_val = ft_ev && !nf_ev;
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         first_fatal <= 1'b0;
         nf_seen     <= 1'b0;
         ft_seen     <= 1'b0;
      end else if (upd_en) begin
         if (capture)      first_fatal <= sev_val;
         else if (clr_sev) first_fatal <= 1'b0;
         if (nf_ev)        nf_seen <= 1'b1;
         else if (clr_nf)  nf_seen <= 1'b0;
         if (ft_ev)        ft_seen <= 1'b1;
         else if (clr_ft)  ft_seen <= 1'b0;
      end
   end

   p_sev_keep_r4: assert property (@(posedge clk) disable iff (!por_n)
      (upd_en && unc_first && !clr_sev) |=> $stable(first_fatal));
   p_seen_ft_r5: assert property (@(posedge clk) disable iff (!por_n)
      (upd_en && ft_ev) |=> ft_seen);
   p_seen_nf_r5: assert property (@(posedge clk) disable iff (!por_n)
      (upd_en && nf_ev) |=> nf_seen);
endmodule

// File: rtl/rootport_err_log.sv
module rootport_err_log
   import rerr_pkg::*;
#(
   parameter int RID_W      = 16,
   parameter int STAT_W     = 32,
   parameter int MSGNUM_W   = 5,
   parameter bit FATAL_PRIO = 1'b1
) (
   input  logic                 clk,
   input  logic                 por_n,
   input  logic                 func_rst_n,
   input  logic                 cor_vld,
   input  logic [RID_W-1:0]     cor_rid,
   input  logic                 nf_vld,
   input  logic [RID_W-1:0]     nf_rid,
   input  logic                 ft_vld,
   input  logic [RID_W-1:0]     ft_rid,
   input  logic                 wr_en,
   input  logic                 wr_sel,
   input  logic [LIVE_BITS-1:0] wr_data,
   output logic [STAT_W-1:0]    status_o,
   output logic [2*RID_W-1:0]   src_id_o
);
   localparam int RSVD_W = STAT_W - MSGNUM_W - LIVE_BITS;

   generate
      if (RID_W < 1) begin : g_bad_rid
         $error("RID_W must be at least 1");
      end
      if (RSVD_W < 0) begin : g_bad_stat
         $error("STAT_W too small for live bits and message number");
      end
   endgenerate

   logic                 upd_en;
   logic [LIVE_BITS-1:0] clr;
   logic [LIVE_BITS-1:0] live;
   logic                 cls_ev    [NUM_CLASSES];
   logic [RID_W-1:0]     cls_rid   [NUM_CLASSES];
   logic                 cls_first [NUM_CLASSES];
   logic                 cls_multi [NUM_CLASSES];
   logic [RID_W-1:0]     cls_log   [NUM_CLASSES];
   logic [RID_W-1:0]     unc_rid;
   logic                 first_fatal, nf_seen, ft_seen;

   assign upd_en = func_rst_n;
   assign clr    = (wr_en && (wr_sel == SEL_STATUS)) ? wr_data : '0;

   generate
      if (FATAL_PRIO) begin : g_rid_fatal
         assign unc_rid = ft_vld ? ft_rid : nf_rid;
      end else begin : g_rid_nonfatal
         assign unc_rid = nf_vld ? nf_rid : ft_rid;
      end
   endgenerate

   assign cls_ev[CLS_COR]  = cor_vld;
   assign cls_rid[CLS_COR] = cor_rid;
   assign cls_ev[CLS_UNC]  = nf_vld || ft_vld;
   assign cls_rid[CLS_UNC] = unc_rid;

   generate
      for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
         rerr_class_log #(.RID_W(RID_W)) u_cls (
            .clk       (clk),
            .por_n     (por_n),
            .upd_en    (upd_en),
            .ev        (cls_ev[c]),
            .ev_rid    (cls_rid[c]),
            .clr_first (clr[2*c]),
            .clr_multi (clr[2*c+1]),
            .first     (cls_first[c]),
            .multi     (cls_multi[c]),
            .rid_log   (cls_log[c])
         );
         assign live[2*c]   = cls_first[c];
         assign live[2*c+1] = cls_multi[c];
         assign src_id_o[c*RID_W +: RID_W] = cls_log[c];
      end
   endgenerate

   rerr_sev_track #(.FATAL_PRIO(FATAL_PRIO)) u_sev (
      .clk         (clk),
      .por_n       (por_n),
      .upd_en      (upd_en),
      .nf_ev       (nf_vld),
      .ft_ev       (ft_vld),
      .unc_first   (cls_first[CLS_UNC]),
      .clr_sev     (clr[FIRST_FATAL_BIT]),
      .clr_nf      (clr[NF_SEEN_BIT]),
      .clr_ft      (clr[FT_SEEN_BIT]),
      .first_fatal (first_fatal),
      .nf_seen     (nf_seen),
      .ft_seen     (ft_seen)
   );

   assign live[FIRST_FATAL_BIT] = first_fatal;
   assign live[NF_SEEN_BIT]     = nf_seen;
   assign live[FT_SEEN_BIT]     = ft_seen;

   generate
      if (RSVD_W > 0) begin : g_rsvd
         assign status_o = {{MSGNUM_W{1'b0}}, {RSVD_W{1'b0}}, live};
      end else begin : g_norsvd
         assign status_o = {{MSGNUM_W{1'b0}}, live};
      end
   endgenerate

   p_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
      !func_rst_n |=> ($stable(status_o) && $stable(src_id_o)));
   p_src_ro_r7: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && wr_sel == SEL_SOURCE && !cor_vld && !nf_vld && !ft_vld)
         |=> ($stable(status_o) && $stable(src_id_o)));
   p_unc_id_r3: assert property (@(posedge clk) disable iff (!por_n)
      (func_rst_n && ft_vld && !live[UNC_FIRST_BIT] && FATAL_PRIO)
         |=> (src_id_o[2*RID_W-1:RID_W] == $past(ft_rid)));
endmodule

// File: tb/sim_rootport_err_log.sv
module sim_rootport_err_log;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        func_rst_n = 1'b1;
   logic        cor_vld = 1'b0, nf_vld = 1'b0, ft_vld = 1'b0;
   logic [15:0] cor_rid = '0, nf_rid = '0, ft_rid = '0;
   logic        wr_en = 1'b0, wr_sel = 1'b0;
   logic [6:0]  wr_data = '0;
   logic [31:0] status_o, src_id_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rootport_err_log u0 (
      .clk(clk), .por_n(por_n), .func_rst_n(func_rst_n),
      .cor_vld(cor_vld), .cor_rid(cor_rid),
      .nf_vld(nf_vld), .nf_rid(nf_rid),
      .ft_vld(ft_vld), .ft_rid(ft_rid),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .status_o(status_o), .src_id_o(src_id_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      cor_vld = 0; nf_vld = 0; ft_vld = 0; wr_en = 0;
   endtask

   task automatic por();
      por_n = 0;
      @(negedge clk);
      por_n = 1;
      @(negedge clk);
   endtask

   task automatic ev(input bit c, input bit n, input bit f,
                     input logic [15:0] cid, input logic [15:0] nid, input logic [15:0] fid);
      cor_vld = c; nf_vld = n; ft_vld = f;
      cor_rid = cid; nf_rid = nid; ft_rid = fid;
   endtask

   task automatic wr(input bit sel, input logic [6:0] d);
      wr_en = 1; wr_sel = sel; wr_data = d;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] e_st, e_src;
      @(negedge clk);
      @(negedge clk);
      chk("R9 por status", status_o, 32'h0);
      chk("R9 por source", src_id_o, 32'h0);
      por_n = 1;
      @(negedge clk);

      // R1 R2 R3 R4 R5 R6 R10: sweep all strobe patterns
      for (int p = 0; p < 8; p++) begin
         bit c, n, f, u;
         c = p[0]; n = p[1]; f = p[2]; u = n | f;
         por();
         ev(c, n, f, 16'h1000 + 16'(p), 16'h2000 + 16'(p), 16'h3000 + 16'(p));
         step();
         e_st = (c ? 32'h01 : 0) | (u ? 32'h04 : 0) | (f ? 32'h10 : 0) |
                (n ? 32'h20 : 0) | (f ? 32'h40 : 0);
         e_src = {(u ? (f ? 16'h3000 + 16'(p) : 16'h2000 + 16'(p)) : 16'h0),
                  (c ? 16'h1000 + 16'(p) : 16'h0)};
         chk("R1 R3 R4 R5 R6 first status", status_o, e_st);
         chk("R1 R3 first source", src_id_o, e_src);
         ev(c, n, f, 16'h1100 + 16'(p), 16'h2100 + 16'(p), 16'h3100 + 16'(p));
         step();
         e_st = e_st | (c ? 32'h02 : 0) | (u ? 32'h08 : 0);
         chk("R2 R3 multi status", status_o, e_st);
         chk("R2 R10 id kept", src_id_o, e_src);
      end

      // R4: fatal after non-fatal does not alter severity
      por();
      ev(0, 1, 0, 0, 16'hAAAA, 0); step();
      ev(0, 0, 1, 0, 0, 16'hBBBB); step();
      chk("R4 severity kept", status_o, 32'h6C);
      chk("R4 id of first", src_id_o, 32'hAAAA_0000);

      // R7: all write-one-to-clear masks, and writes to the source word
      for (int m = 0; m < 128; m++) begin
         por();
         ev(1, 1, 1, 16'h0C0C, 16'h0D0D, 16'h0F0F); step();
         ev(1, 1, 1, 16'h1C1C, 16'h1D1D, 16'h1F1F); step();
         wr(0, 7'(m)); step();
         chk("R7 w1c mask", status_o, 32'h7F & ~32'(m));
         wr(1, 7'h7F); step();
         chk("R7 source write status", status_o, 32'h7F & ~32'(m));
         chk("R7 source write ignored", src_id_o, 32'h0F0F_0C0C);
      end

      // R8: full clear collides with all strobes
      por();
      ev(1, 1, 1, 16'h0001, 16'h0002, 16'h0003); step();
      ev(1, 1, 1, 16'h0001, 16'h0002, 16'h0003); step();
      ev(1, 1, 1, 16'h0011, 16'h0012, 16'h0013); wr(0, 7'h7F); step();
      chk("R8 set wins", status_o, 32'h6F);
      chk("R8 ids kept", src_id_o, 32'h0003_0001);

      // R8: clear first-cor while cor arrives
      por();
      ev(1, 0, 0, 16'h5555, 0, 0); step();
      ev(1, 0, 0, 16'h6666, 0, 0); wr(0, 7'h01); step();
      chk("R8 cor collision", status_o, 32'h03);
      chk("R8 cor id kept", src_id_o, 32'h0000_5555);

      // R10: relog after clear
      por();
      ev(1, 0, 0, 16'h1234, 0, 0); step();
      wr(0, 7'h01); step();
      chk("R10 cleared", status_o, 32'h0);
      ev(1, 0, 0, 16'h4321, 0, 0); step();
      chk("R10 relog status", status_o, 32'h01);
      chk("R10 relog id", src_id_o, 32'h0000_4321);

      // R9: functional reset freezes and retains
      por();
      ev(1, 1, 1, 16'h0A0A, 16'h0B0B, 16'h0C0C); step();
      func_rst_n = 0;
      for (int k = 0; k < 3; k++) begin
         ev(1, 1, 0, 16'hEEEE, 16'hDDDD, 0); wr(0, 7'h7F); step();
         chk("R9 frozen status", status_o, 32'h75);
         chk("R9 frozen source", src_id_o, 32'h0C0C_0A0A);
      end
      func_rst_n = 1;
      @(negedge clk);
      chk("R9 retained status", status_o, 32'h75);
      chk("R9 retained source", src_id_o, 32'h0C0C_0A0A);
      por();
      chk("R9 por clears status", status_o, 32'h0);
      chk("R9 por clears source", src_id_o, 32'h0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule